// File: doc/BRIEF.md
# Frame Status Queue

This block sits beside a synchronous serial frame receiver and keeps one status record for each frame that has ended. A record holds the frame's received byte count (14 bits) and two error flags. It is written by a single-cycle push strobe from the receiver at frame end. The records wait in a first-in, first-out queue until the host reads them through a small register window.

The host reads three registers. The status register packs a data-available bit, a sticky overflow bit and the top six count bits of the oldest record. The low-count register gives the lower eight count bits and also removes that record. The error register gives the record's flags. When the queue holds nothing, or when the queue enable input is low, the status register shows the receiver's live status byte instead. An overflow is cleared only by taking the enable low for at least one clock and raising it again. That same action also empties the queue.

Control is a four-state machine. OFF is entered whenever enable is sampled low. From OFF, EMPTY, PART or FULL, enable sampled high moves the machine by the next occupancy: to EMPTY when the level is zero (transition *drain*), to PART for 1..DEPTH-1 records (*fill* or *drain*), and to FULL at DEPTH (*saturate*). Enable sampled low always gives the transition *shutdown* to OFF. OFF with enable high behaves as an empty queue.

Top module: `frame_status_queue`

## Requirements
- R1: While enabled and non-empty, a read at address 0 returns bit 7 = 1, bit 6 = overflow flag, bits 5:0 = count bits 13:8 of the oldest record.
- R2: While enabled and empty, a read at address 0 returns `live_status` unchanged.
- R3: While `q_en` is 0, a read at address 0 returns `live_status`, and push strobes are discarded.
- R4: Address 1 returns count bits 7:0 of the oldest record, and address 2 returns {6'b0, error flags}. Both return 0 (as does address 3) when empty or disabled.
- R5: A read strobe at address 1 removes the oldest record, and the next record is visible from the following cycle. The strobe is ignored on an empty queue.
- R6: The queue holds 10 records in arrival order. A record pushed while 10 are held is dropped, and the stored ones are kept.
- R7: A push while full sets the overflow flag. The flag stays set through later pops and pushes while enabled.
- R8: Driving `q_en` low for one or more cycles and then high leaves the queue empty and the overflow flag clear.
- R9: A push and a pop in the same cycle on a non-empty, non-full queue both take effect.
- R10: After reset the queue is empty and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_en | input | 1 | Queue enable; low clears queue and overflow |
| rec_push | input | 1 | Frame-end strobe that writes one record |
| rec_count | input | 14 | Byte count of the ended frame |
| rec_err | input | 2 | Error flags of the ended frame |
| live_status | input | 8 | Live receiver status byte |
| rd_stb | input | 1 | Host read strobe (pops at address 1) |
| rd_addr | input | 2 | Host register address: 0 status, 1 low count, 2 errors |
| rd_data | output | 8 | Read data, combinational from address and state |

## Verification
Read data is combinational, so a register read is due in the same cycle its address is presented. A push, a pop or an enable change shows in the reads only after the next rising edge. The bench drives every input at a falling edge and samples one nanosecond after the following falling edge. It therefore always observes the state one rising edge after a stimulus. Pop reads take the low byte before that edge and the status byte after it.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } fsq_state_e;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_LOW  = 2'd1;
    localparam logic [1:0] ADDR_ERR  = 2'd2;
endpackage

// File: rtl/fsq_store.sv
module fsq_store #(
    parameter int DEPTH = 10,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_adv,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wptr == PTR_W'(i))
                slots[i] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en)  wptr <= step(wptr);
            if (rd_adv) rptr <= step(rptr);
        end
    end

    assign head = slots[rptr];
endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic push_i,
    input  logic pop_i,
    output logic wr_en_o,
    output logic rd_adv_o,
    output logic clr_o,
    output logic empty_o,
    output logic ovf_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    fsq_state_e       state, state_nxt;
    logic [LVL_W-1:0] level, level_nxt;
    logic             push_ok, pop_ok, ovf_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            level <= '0;
            ovf_o <= 1'b0;
        end else begin
            state <= state_nxt;
            level <= level_nxt;
            ovf_o <= ovf_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        push_ok   = en_i && push_i && (state != ST_FULL);
        pop_ok    = en_i && pop_i && (level != '0);
        level_nxt = en_i ? (level + LVL_W'(push_ok) - LVL_W'(pop_ok)) : '0;
        ovf_nxt   = en_i && (ovf_o || (push_i && state == ST_FULL));
        state_nxt = state;
        unique case (state)
            ST_OFF, ST_EMPTY, ST_PART, ST_FULL: begin
                if (!en_i)                    state_nxt = ST_OFF;   // shutdown
                else if (level_nxt == '0)     state_nxt = ST_EMPTY; // drain
                else if (level_nxt == FULL_LVL) state_nxt = ST_FULL; // saturate
                else                          state_nxt = ST_PART;  // fill/drain
            end
            default: state_nxt = ST_OFF;
        endcase
        wr_en_o  = push_ok;
        rd_adv_o = pop_ok;
        clr_o    = !en_i;
        empty_o  = (state == ST_OFF) || (state == ST_EMPTY);
    end

    // R7: overflow stays set while enabled
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && en_i) |=> ovf_o);
    // R7: a push into a full queue raises overflow
    a_r7_full_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && en_i && push_i) |=> ovf_o);
    // R6: occupancy never exceeds the depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    // R8: a low enable clears occupancy and overflow
    a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (empty_o && !ovf_o));
    // R5: pop on empty queue leaves it empty
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && en_i && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/fsq_rdmux.sv
module fsq_rdmux
    import fsq_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int ERR_W = 2
) (
    input  logic             en_i,
    input  logic             empty_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] head_cnt,
    input  logic [ERR_W-1:0] head_err,
    input  logic [7:0]       live_i,
    input  logic [1:0]       addr_i,
    output logic [7:0]       data_o
);
    localparam int HI_W = CNT_W - 8;

    logic served;
    assign served = en_i && !empty_i;

    always_comb begin
        data_o = '0;
        unique case (addr_i)
            ADDR_STAT: data_o = served ? {1'b1, ovf_i, head_cnt[CNT_W-1 -: HI_W]} : live_i;
            ADDR_LOW:  data_o = served ? head_cnt[7:0] : 8'h00;
            ADDR_ERR:  data_o = served ? 8'(head_err) : 8'h00;
            default:   data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/frame_status_queue.sv
module frame_status_queue
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = 14,
    parameter int ERR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_en,
    input  logic             rec_push,
    input  logic [CNT_W-1:0] rec_count,
    input  logic [ERR_W-1:0] rec_err,
    input  logic [7:0]       live_status,
    input  logic             rd_stb,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data
);
    localparam int REC_W = CNT_W + ERR_W;

    logic             wr_en, rd_adv, clr, empty, ovf, pop_req;
    logic [REC_W-1:0] head;

    assign pop_req = rd_stb && (rd_addr == ADDR_LOW);

    fsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(q_en), .push_i(rec_push), .pop_i(pop_req),
        .wr_en_o(wr_en), .rd_adv_o(rd_adv), .clr_o(clr), .empty_o(empty), .ovf_o(ovf)
    );

    fsq_store #(.DEPTH(DEPTH), .W(REC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_data({rec_err, rec_count}), .rd_adv(rd_adv), .head(head)
    );

    fsq_rdmux #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_mux (
        .en_i(q_en), .empty_i(empty), .ovf_i(ovf),
        .head_cnt(head[CNT_W-1:0]), .head_err(head[REC_W-1 -: ERR_W]),
        .live_i(live_status), .addr_i(rd_addr), .data_o(rd_data)
    );

    // R2/R3: bypassed status reads return the live byte
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_STAT && (!q_en || empty)) |-> rd_data == live_status);
    // R1: a served status read flags data available
    a_r1_da_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_STAT && q_en && !empty) |-> rd_data[7]);
endmodule

// File: tb/sim_frame_status_queue.sv
module sim_frame_status_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, q_en = 1'b0, rec_push = 1'b0, rd_stb = 1'b0;
    logic [13:0] rec_count = '0;
    logic [1:0]  rec_err = '0, rd_addr = '0;
    logic [7:0]  live_status = 8'h5A, rd_data, v;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frame_status_queue u0 (.*);

    // {op(0 idle,1 push,2 pop), err, count, expected status byte}
    localparam logic [25:0] VEC [8] = '{
        {2'd1, 2'd0, 14'h3FFF, 8'hBF},
        {2'd1, 2'd0, 14'h0123, 8'hBF},
        {2'd2, 2'd0, 14'h0000, 8'h81},
        {2'd2, 2'd0, 14'h0000, 8'h5A},
        {2'd2, 2'd0, 14'h0000, 8'h5A},
        {2'd1, 2'd3, 14'h2A55, 8'hAA},
        {2'd0, 2'd0, 14'h0000, 8'hAA},
        {2'd2, 2'd0, 14'h0000, 8'h5A}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // one cycle: drive at falling edge, return at next falling edge
    task automatic cyc(input bit psh, input logic [13:0] c, input logic [1:0] e, input bit pop);
        rec_push = psh; rec_count = c; rec_err = e;
        rd_stb = pop; rd_addr = pop ? 2'd1 : 2'd0;
        @(negedge clk);
        rec_push = 0; rd_stb = 0; rd_addr = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(2'd0, v); chk(v, 8'h5A, "R10 reset/disabled status");
        rd(2'd1, v); chk(v, 8'h00, "R10 reset low count");
        q_en = 1; @(negedge clk);
        rd(2'd0, v); chk(v, 8'h5A, "R2 empty status live");

        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i][25:24] == 2'd1, VEC[i][21:8], VEC[i][23:22], VEC[i][25:24] == 2'd2);
            rd(2'd0, v); chk(v, VEC[i][7:0], $sformatf("R1/R5 vector %0d", i));
        end

        cyc(1, 14'h2A55, 2'd3, 0);
        rd(2'd1, v); chk(v, 8'h55, "R4 low count");
        rd(2'd2, v); chk(v, 8'h03, "R4 error flags");
        cyc(0, 0, 0, 1);
        rd(2'd1, v); chk(v, 8'h00, "R4 low count empty");
        rd(2'd3, v); chk(v, 8'h00, "R4 unused address");

        cyc(1, 14'h0100, 0, 0);
        cyc(1, 14'h0200, 0, 1);
        rd(2'd0, v); chk(v, 8'h82, "R9 push+pop head");
        cyc(0, 0, 0, 1);
        rd(2'd0, v); chk(v, 8'h5A, "R9 single record left");

        for (int i = 0; i < 10; i++) cyc(1, {i[5:0], i[7:0]}, 0, 0);
        rd(2'd0, v); chk(v, 8'h80, "R6 full, no overflow");
        cyc(1, 14'h3F00, 0, 0);
        rd(2'd0, v); chk(v, 8'hC0, "R7 overflow set");
        for (int i = 0; i < 10; i++) begin
            rd(2'd0, v); chk(v, 8'hC0 | 8'(i), $sformatf("R6 order status %0d", i));
            rd(2'd1, v); chk(v, 8'(i), $sformatf("R6 order low %0d", i));
            cyc(0, 0, 0, 1);
        end
        rd(2'd0, v); chk(v, 8'h5A, "R6 dropped record absent");
        cyc(1, 14'h0500, 0, 0);
        rd(2'd0, v); chk(v, 8'hC5, "R7 overflow sticky");

        q_en = 0; live_status = 8'h33;
        cyc(1, 14'h0900, 0, 0);
        rd(2'd0, v); chk(v, 8'h33, "R3 disabled live");
        q_en = 1; @(negedge clk);
        rd(2'd0, v); chk(v, 8'h33, "R8 queue cleared");
        cyc(1, 14'h0700, 0, 0);
        rd(2'd0, v); chk(v, 8'h87, "R8 overflow cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule